// File: doc/BRIEF.md
# Four-Valued Shared Bus Line Resolver

This block works out the value a set of shared bus lines settles to when several drivers can place a value on each line at once. Each driver presents, for every bit lane, one of four logic values: zero, one, high-impedance (Z) or unknown (X). The block merges all drivers lane by lane and gives one resolved four-valued code per lane. It is purely combinational and has no clock.

A bus that several sources share relies on arbitration so that only one source drives at a time. The block also checks that arbitration. Each lane has a clash flag that rises whenever more than one driver on that lane is active (not Z). This holds even when the active drivers agree, because two drivers holding the same level can still conflict while they switch. A single summary flag shows a clash on any lane. The driver count and the bus width are parameters, and a single driver is allowed.

Top module: `bus_lane_resolver`

## Requirements
- R1: Each lane value is a 2-bit code: 2'b00 is zero, 2'b01 is one, 2'b10 is Z, 2'b11 is X. The code of driver d, lane l sits at bits [(d*WIDTH+l)*2 +: 2] of `drv_codes`. The resolved code of lane l sits at bits [l*2 +: 2] of `bus_codes`.
- R2: When one driver gives zero and another gives one on the same lane, that lane resolves to X.
- R3: When any driver on a lane gives X, that lane resolves to X, whatever the other drivers give.
- R4: When exactly one driver on a lane gives zero or one and all the others give Z, the lane resolves to that value.
- R5: A lane resolves to Z only when every driver on it gives Z.
- R6: Several active drivers that all give the same value (all zero or all one) resolve to that value.
- R7: `lane_clash[l]` is 1 exactly when more than one driver on lane l gives a code other than Z. This includes the agreeing case of R6. A single active driver gives no clash.
- R8: `any_clash` is 1 exactly when at least one bit of `lane_clash` is 1.
- R9: Lanes resolve independently: what drivers place on one lane does not affect the result or the clash flag of any other lane.
- R10: The result does not depend on driver order: swapping drivers leaves every output unchanged.
- R11: With a single driver (NDRV = 1), each lane repeats that driver's code and no clash is ever flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| drv_codes | input | NDRV*WIDTH*2 | Packed four-valued codes of all drivers, driver-major |
| bus_codes | output | WIDTH*2 | Resolved four-valued code of each lane |
| lane_clash | output | WIDTH | Per-lane flag: more than one active driver |
| any_clash | output | 1 | Clash present on at least one lane |

## Verification
The hardest cases to reach are lanes where the result and the clash flag move apart. Two agreeing drivers give a clean zero or one but must still raise the clash flag. One lane in conflict must not disturb its neighbours. Directed tasks build these patterns on chosen lanes while the other lanes hold different patterns. A pseudo-random sweep then applies mixed four-valued patterns. Each pattern is checked against a model written from the requirements, and checked again with the driver order reversed, which covers order independence. A second instance with one driver covers the degenerate case.

// File: rtl/bus_lane_resolver.sv
module bus_lane_resolver #(
  parameter int NDRV  = 4,
  parameter int WIDTH = 8
) (
  input  logic [NDRV*WIDTH*2-1:0] drv_codes,
  output logic [WIDTH*2-1:0]      bus_codes,
  output logic [WIDTH-1:0]        lane_clash,
  output logic                    any_clash
);

  localparam logic [1:0] V0 = 2'b00;
  localparam logic [1:0] V1 = 2'b01;
  localparam logic [1:0] VZ = 2'b10;
  localparam logic [1:0] VX = 2'b11;

  genvar l, d;
  generate
    for (l = 0; l < WIDTH; l++) begin : g_lane
      logic seen0, seen1, seenx, seen_act, multi;
      logic [NDRV-1:0] act;
      logic [1:0] res;

      for (d = 0; d < NDRV; d++) begin : g_act
        assign act[d] = drv_codes[(d*WIDTH+l)*2 +: 2] != VZ;
      end

      always_comb begin
        seen0    = 1'b0;
        seen1    = 1'b0;
        seenx    = 1'b0;
        seen_act = 1'b0;
        multi    = 1'b0;
        for (int i = 0; i < NDRV; i++) begin
          case (drv_codes[(i*WIDTH+l)*2 +: 2])
            V0:      seen0 = 1'b1;
            V1:      seen1 = 1'b1;
            VX:      seenx = 1'b1;
            default: ;
          endcase
          if (drv_codes[(i*WIDTH+l)*2 +: 2] != VZ) begin
            multi    = multi | seen_act;
            seen_act = 1'b1;
          end
        end
      end

      assign res = (seenx || (seen0 && seen1)) ? VX :
                   seen0 ? V0 :
                   seen1 ? V1 : VZ;
      assign bus_codes[l*2 +: 2] = res;
      assign lane_clash[l]       = multi;

      always_comb begin
        AST_CLASH_COUNT: assert (lane_clash[l] == ($countones(act) > 1)) else $error("clash count"); // R7
        AST_Z_ONLY_IDLE: assert ((bus_codes[l*2 +: 2] != VZ) || (act == '0)) else $error("Z with active"); // R5
        for (int k = 0; k < NDRV; k++) begin
          AST_ZERO_CLEAN: assert ((bus_codes[l*2 +: 2] != V0) ||
                                  (drv_codes[(k*WIDTH+l)*2 +: 2] inside {V0, VZ})) else $error("zero dirty"); // R2
          AST_ONE_CLEAN:  assert ((bus_codes[l*2 +: 2] != V1) ||
                                  (drv_codes[(k*WIDTH+l)*2 +: 2] inside {V1, VZ})) else $error("one dirty"); // R3
        end
      end
    end
  endgenerate

  assign any_clash = |lane_clash;

  always_comb begin
    AST_ANY_FLAG: assert (any_clash == (lane_clash != '0)) else $error("any flag"); // R8
  end

endmodule

// File: tb/bus_lane_resolver_tb.sv
module bus_lane_resolver_tb;
  localparam int NDRV = 4;
  localparam int WIDTH = 8;
  localparam logic [1:0] V0 = 2'b00, V1 = 2'b01, VZ = 2'b10, VX = 2'b11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NDRV*WIDTH*2-1:0] drv;
  logic [WIDTH*2-1:0]      bus;
  logic [WIDTH-1:0]        clash;
  logic                    anyc;

  logic [3:0] one_drv;
  logic [3:0] one_bus;
  logic [1:0] one_clash;
  logic       one_any;

  int checks = 0;
  int fails  = 0;

  bus_lane_resolver #(.NDRV(NDRV), .WIDTH(WIDTH)) u_dut (
    .drv_codes(drv), .bus_codes(bus), .lane_clash(clash), .any_clash(anyc));

  bus_lane_resolver #(.NDRV(1), .WIDTH(2)) u_one (
    .drv_codes(one_drv), .bus_codes(one_bus), .lane_clash(one_clash), .any_clash(one_any));

  function automatic logic [1:0] ref_lane(logic [NDRV*WIDTH*2-1:0] v, int l);
    int n0 = 0, n1 = 0, nx = 0;
    for (int d = 0; d < NDRV; d++) begin
      case (v[(d*WIDTH+l)*2 +: 2])
        V0: n0++;
        V1: n1++;
        VX: nx++;
        default: ;
      endcase
    end
    if (nx > 0 || (n0 > 0 && n1 > 0)) return VX;
    if (n0 > 0) return V0;
    if (n1 > 0) return V1;
    return VZ;
  endfunction

  function automatic logic ref_clash(logic [NDRV*WIDTH*2-1:0] v, int l);
    int n = 0;
    for (int d = 0; d < NDRV; d++) if (v[(d*WIDTH+l)*2 +: 2] != VZ) n++;
    return n > 1;
  endfunction

  task automatic put(int d, int l, logic [1:0] c);
    drv[(d*WIDTH+l)*2 +: 2] = c;
  endtask

  task automatic all_z();
    for (int i = 0; i < NDRV*WIDTH; i++) drv[i*2 +: 2] = VZ;
  endtask

  task automatic check(string req, logic [WIDTH*2-1:0] eb, logic [WIDTH-1:0] ec, logic ea);
    #2;
    checks++;
    if (bus !== eb || clash !== ec || anyc !== ea) begin
      fails++;
      $display("FAIL %s: bus=%h clash=%b any=%b expected bus=%h clash=%b any=%b",
               req, bus, clash, anyc, eb, ec, ea);
    end
  endtask

  task automatic check_model(string req);
    logic [WIDTH*2-1:0] eb;
    logic [WIDTH-1:0] ec;
    for (int l = 0; l < WIDTH; l++) begin
      eb[l*2 +: 2] = ref_lane(drv, l);
      ec[l] = ref_clash(drv, l);
    end
    check(req, eb, ec, |ec);
  endtask

  task automatic t_idle();
    all_z();
    check("R5 all Z", {WIDTH{VZ}}, '0, 1'b0);
  endtask

  task automatic t_single();
    for (int d = 0; d < NDRV; d++) begin
      for (int v = 0; v < 2; v++) begin
        logic [WIDTH*2-1:0] eb = {WIDTH{VZ}};
        all_z();
        put(d, 3, v[1:0]);
        eb[3*2 +: 2] = v[1:0];
        check("R4 single active", eb, '0, 1'b0);
      end
    end
  endtask

  task automatic t_conflict();
    logic [WIDTH*2-1:0] eb = {WIDTH{VZ}};
    all_z();
    put(0, 1, V0);
    put(2, 1, V1);
    eb[1*2 +: 2] = VX;
    check("R2 zero vs one", eb, 8'b0000_0010, 1'b1);
  endtask

  task automatic t_xdom();
    logic [WIDTH*2-1:0] eb = {WIDTH{VZ}};
    all_z();
    put(3, 0, VX);
    eb[0 +: 2] = VX;
    check("R3 lone X", eb, '0, 1'b0);
    put(1, 0, V1);
    check("R3 X with one", eb, 8'b0000_0001, 1'b1);
    all_z();
    put(0, 6, V0);
    put(2, 6, VX);
    put(3, 6, V0);
    eb = {WIDTH{VZ}};
    eb[6*2 +: 2] = VX;
    check("R3 X with zeros", eb, 8'b0100_0000, 1'b1);
  endtask

  task automatic t_agree();
    logic [WIDTH*2-1:0] eb = {WIDTH{VZ}};
    all_z();
    put(1, 5, V1);
    put(3, 5, V1);
    eb[5*2 +: 2] = V1;
    check("R6 R7 two ones", eb, 8'b0010_0000, 1'b1);
    all_z();
    for (int d = 0; d < NDRV; d++) put(d, 7, V0);
    eb = {WIDTH{VZ}};
    eb[7*2 +: 2] = V0;
    check("R6 R7 all zero", eb, 8'b1000_0000, 1'b1);
  endtask

  task automatic t_lanes();
    logic [WIDTH*2-1:0] eb = {WIDTH{VZ}};
    all_z();
    put(0, 2, V1);
    put(1, 3, V0);
    put(2, 4, VX);
    eb[2*2 +: 2] = V1;
    eb[3*2 +: 2] = V0;
    eb[4*2 +: 2] = VX;
    check("R9 R8 lanes apart no clash", eb, '0, 1'b0);
    put(1, 2, V0);
    put(3, 2, V0);
    eb[2*2 +: 2] = VX;
    check("R9 R8 one lane clash", eb, 8'b0000_0100, 1'b1);
  endtask

  task automatic t_order();
    logic [31:0] lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 200; n++) begin
      logic [NDRV*WIDTH*2-1:0] pat, rev;
      logic [WIDTH*2-1:0] b0;
      logic [WIDTH-1:0] c0;
      for (int i = 0; i < NDRV*WIDTH; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pat[i*2 +: 2] = (lfsr[3:2] == 2'b00) ? lfsr[1:0] : VZ;
      end
      drv = pat;
      check_model("R1 R10 random pattern");
      b0 = bus;
      c0 = clash;
      for (int d = 0; d < NDRV; d++)
        rev[d*WIDTH*2 +: WIDTH*2] = pat[(NDRV-1-d)*WIDTH*2 +: WIDTH*2];
      drv = rev;
      check("R10 reversed order", b0, c0, |c0);
    end
  endtask

  task automatic t_one();
    for (int v = 0; v < 16; v++) begin
      one_drv = v[3:0];
      #2;
      checks++;
      if (one_bus !== v[3:0] || one_clash !== 2'b00 || one_any !== 1'b0) begin
        fails++;
        $display("FAIL R11: bus=%h clash=%b any=%b expected bus=%h clash=00 any=0",
                 one_bus, one_clash, one_any, v[3:0]);
      end
    end
  endtask

  initial begin
    fork
      begin
        all_z();
        one_drv = 4'hA;
        @(negedge clk);
        t_idle();
        t_single();
        t_conflict();
        t_xdom();
        t_agree();
        t_lanes();
        t_order();
        t_one();
      end
      begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule